// File: doc/BRIEF.md
# Two-Level Global-History Direction Predictor

This block predicts whether a conditional branch will be taken. It is meant to sit beside the fetch stage of a pipelined core. A global history register records the outcomes of the most recently resolved branches. A pattern table of 2-bit saturating counters is indexed by a hash of the fetch address and that history. Because the history is part of the index, the table can learn short repeating outcome patterns, such as the exit of a small inner loop, and not only a fixed bias for each branch.

Fetch presents a PC on the lookup port. In the same cycle it receives a taken/not-taken guess and a copy of the current history, which it keeps with the branch. When the branch resolves, the pipeline returns the PC, that history copy, the real outcome and a flag saying whether the guess was wrong. The block then trains the counter the lookup used. It also advances the history, or restores it from the copy when the guess was wrong. A parameter chooses whether the PC bits and the history bits are concatenated or XORed to form the table index.

Top module: `bp2l_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the history is all zeros, so every lookup returns predTaken=0 and predHist=0.
- R2: predTaken is the upper bit of the addressed counter. Values 10 and 11 predict taken (1); values 00 and 01 predict not taken (0). The result is combinational from lookupPc in the same cycle.
- R3: On a resolve, a taken outcome raises the addressed counter by one and a not-taken outcome lowers it by one. The counter stops at 11 and at 00 and does not wrap.
- R4: On a resolve with resolveMispredict=0, the history shifts left by one and the outcome enters at bit 0 (1 = taken). The new value appears on predHist in the next cycle.
- R5: On a resolve with resolveMispredict=1, the history is loaded with resolveHist shifted left by one, with the outcome at bit 0. The current history is discarded.
- R6: The counter that a resolve trains is chosen from resolvePc and resolveHist, not from the current history.
- R7: In concatenate mode the index is {pc[PC_IDX_W+1:2], hist}. PC bits 1:0 and the bits above PC_IDX_W+1 do not affect the index.
- R8: In XOR mode the index is pc[PC_IDX_W+1:2] XOR the zero-extended history, so distinct PC/history pairs with equal XOR share one counter.
- R9: With 3 history bits, a branch that repeats the outcome stream 1,1,1,0 and is always resolved with its own lookup snapshot is mispredicted at least once while it learns, and never once it is trained.
- R10: In cycles with resolveValid=0, neither the history nor any counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lookupPc | input | PC_W | Fetch address to predict |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predHist | output | HIST_W | Current global history, kept by fetch as the snapshot |
| resolveValid | input | 1 | A branch outcome is presented this cycle |
| resolvePc | input | PC_W | Address of the resolved branch |
| resolveHist | input | HIST_W | History snapshot taken at its lookup |
| resolveTaken | input | 1 | Actual outcome, 1 = taken |
| resolveMispredict | input | 1 | The earlier prediction was wrong |

## Verification
A single counter is first driven up and down through every state and past both limits. The lookup is read after each step, which separates proper saturation and hysteresis from wrap-around or a plain last-outcome bit. Resolves whose snapshot differs from the live history show whether training is steered by the snapshot. Paired mispredicted and correctly predicted resolves separate restoring the history from shifting it. The repeating 1,1,1,0 loop stream, fed back through the lookup snapshots, checks that the learning phase misses and the trained phase does not. An aliasing pair of addresses on an XOR-mode instance, and addresses that differ only outside the index bits on a concatenate instance, show which PC and history bits reach the index.

// File: rtl/bp2l_pkg.sv
package bp2l_pkg;

  typedef enum logic {
    IDX_CONCAT = 1'b0,
    IDX_XOR    = 1'b1
  } idxMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ctrWrite;
    logic ctrUp;
    logic histRestore;
    logic histShift;
  } bpStrobe_t;

  localparam logic [1:0] CTR_INIT = 2'b01;
  localparam logic [1:0] CTR_MAX  = 2'b11;
  localparam logic [1:0] CTR_MIN  = 2'b00;

endpackage

// File: rtl/bp2l_ctrl.sv
module bp2l_ctrl
  import bp2l_pkg::*;
#(
  parameter int       PC_W       = 32,
  parameter int       PC_IDX_W   = 4,
  parameter int       HIST_W     = 3,
  parameter int       IDX_W      = 7,
  parameter idxMode_e INDEX_MODE = IDX_CONCAT
) (
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [HIST_W-1:0] curHist,
  input  logic              resolveValid,
  input  logic [PC_W-1:0]   resolvePc,
  input  logic [HIST_W-1:0] resolveHist,
  input  logic              resolveTaken,
  input  logic              resolveMispredict,
  output logic [IDX_W-1:0]  lookupIdx,
  output logic [IDX_W-1:0]  resolveIdx,
  output bpStrobe_t         strobe
);

  localparam int PC_LO = 2;
  localparam int PC_HI = PC_LO + PC_IDX_W - 1;

  logic [PC_IDX_W-1:0] lookupPcBits;
  logic [PC_IDX_W-1:0] resolvePcBits;

  assign lookupPcBits  = lookupPc[PC_HI:PC_LO];
  assign resolvePcBits = resolvePc[PC_HI:PC_LO];

  generate
    if (INDEX_MODE == IDX_CONCAT) begin : g_concat
      assign lookupIdx  = {lookupPcBits, curHist};
      assign resolveIdx = {resolvePcBits, resolveHist};
    end else begin : g_xor
      assign lookupIdx  = lookupPcBits ^ PC_IDX_W'(curHist);
      assign resolveIdx = resolvePcBits ^ PC_IDX_W'(resolveHist);
    end
  endgenerate

  // word-aligned fetch: low bits and upper bits never reach the index
  logic unusedPcBits;
  assign unusedPcBits = ^{lookupPc[PC_W-1:PC_HI+1], lookupPc[PC_LO-1:0],
                          resolvePc[PC_W-1:PC_HI+1], resolvePc[PC_LO-1:0]};

  always_comb begin
    strobe.ctrWrite    = resolveValid;
    strobe.ctrUp       = resolveTaken;
    strobe.histRestore = resolveValid & resolveMispredict;
    strobe.histShift   = resolveValid & ~resolveMispredict;
  end

endmodule

// File: rtl/bp2l_datapath.sv
module bp2l_datapath
  import bp2l_pkg::*;
#(
  parameter int HIST_W = 3,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  lookupIdx,
  input  logic [IDX_W-1:0]  resolveIdx,
  input  logic [HIST_W-1:0] resolveHist,
  input  logic              resolveTaken,
  input  bpStrobe_t         strobe,
  output logic              predTaken,
  output logic [HIST_W-1:0] curHist
);

  localparam int DEPTH = 1 << IDX_W;

  logic [1:0]        patTable [DEPTH];
  logic [1:0]        ctrOld;
  logic [1:0]        ctrNew;
  logic [HIST_W-1:0] histNext;

  assign predTaken = patTable[lookupIdx][1];
  assign ctrOld    = patTable[resolveIdx];

  always_comb begin
    if (strobe.ctrUp) begin
      ctrNew = (ctrOld == CTR_MAX) ? CTR_MAX : ctrOld + 2'd1;
    end else begin
      ctrNew = (ctrOld == CTR_MIN) ? CTR_MIN : ctrOld - 2'd1;
    end
  end

  always_comb begin
    histNext = curHist;
    if (strobe.histRestore) begin
      histNext = {resolveHist[HIST_W-2:0], resolveTaken};
    end else if (strobe.histShift) begin
      histNext = {curHist[HIST_W-2:0], resolveTaken};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        patTable[i] <= CTR_INIT;
      end
    end else if (strobe.ctrWrite) begin
      patTable[resolveIdx] <= ctrNew;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curHist <= '0;
    end else begin
      curHist <= histNext;
    end
  end

endmodule

// File: rtl/bp2l_predictor.sv
module bp2l_predictor
  import bp2l_pkg::*;
#(
  parameter int       PC_W       = 32,
  parameter int       PC_IDX_W   = 4,
  parameter int       HIST_W     = 3,
  parameter idxMode_e INDEX_MODE = IDX_CONCAT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   lookupPc,
  output logic              predTaken,
  output logic [HIST_W-1:0] predHist,
  input  logic              resolveValid,
  input  logic [PC_W-1:0]   resolvePc,
  input  logic [HIST_W-1:0] resolveHist,
  input  logic              resolveTaken,
  input  logic              resolveMispredict
);

  localparam int IDX_W = (INDEX_MODE == IDX_CONCAT) ? (PC_IDX_W + HIST_W) : PC_IDX_W;

  logic [IDX_W-1:0] lookupIdx;
  logic [IDX_W-1:0] resolveIdx;
  bpStrobe_t        strobe;

  bp2l_ctrl #(
    .PC_W(PC_W), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W),
    .IDX_W(IDX_W), .INDEX_MODE(INDEX_MODE)
  ) u_ctrl (
    .lookupPc(lookupPc),
    .curHist(predHist),
    .resolveValid(resolveValid),
    .resolvePc(resolvePc),
    .resolveHist(resolveHist),
    .resolveTaken(resolveTaken),
    .resolveMispredict(resolveMispredict),
    .lookupIdx(lookupIdx),
    .resolveIdx(resolveIdx),
    .strobe(strobe)
  );

  bp2l_datapath #(
    .HIST_W(HIST_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .lookupIdx(lookupIdx),
    .resolveIdx(resolveIdx),
    .resolveHist(resolveHist),
    .resolveTaken(resolveTaken),
    .strobe(strobe),
    .predTaken(predTaken),
    .curHist(predHist)
  );

endmodule

// File: rtl/bp2l_checker.sv
module bp2l_checker #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   lookupPc,
  input logic              predTaken,
  input logic [HIST_W-1:0] predHist,
  input logic              resolveValid,
  input logic [HIST_W-1:0] resolveHist,
  input logic              resolveTaken,
  input logic              resolveMispredict
);

  // R4
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && !resolveMispredict) |=>
      predHist == {$past(predHist[HIST_W-2:0]), $past(resolveTaken)});

  // R5
  hist_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && resolveMispredict) |=>
      predHist == {$past(resolveHist[HIST_W-2:0]), $past(resolveTaken)});

  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resolveValid |=> $stable(predHist));

  // R10
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!resolveValid ##1 $stable(lookupPc)) |-> $stable(predTaken));

endmodule

bind bp2l_predictor bp2l_checker #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (.*);

// File: tb/bp2l_predictor_bench.sv
module bp2l_predictor_bench;
  import bp2l_pkg::*;

  localparam int  CLK_PERIOD = 10;
  localparam int  PC_W   = 32;
  localparam int  HIST_W = 3;
  localparam logic [PC_W-1:0] PC_A = 32'h0000_0010; // index PC bits = 4
  localparam logic [PC_W-1:0] PC_B = 32'h0000_0020; // index PC bits = 8

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  // concatenate-mode instance
  logic [PC_W-1:0]   lookupPc = '0;
  logic              predTaken;
  logic [HIST_W-1:0] predHist;
  logic              resolveValid = 1'b0;
  logic [PC_W-1:0]   resolvePc = '0;
  logic [HIST_W-1:0] resolveHist = '0;
  logic              resolveTaken = 1'b0;
  logic              resolveMispredict = 1'b0;

  bp2l_predictor #(.PC_W(PC_W), .PC_IDX_W(4), .HIST_W(HIST_W), .INDEX_MODE(IDX_CONCAT)) u_bp2l_predictor (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predTaken), .predHist(predHist),
    .resolveValid(resolveValid), .resolvePc(resolvePc), .resolveHist(resolveHist),
    .resolveTaken(resolveTaken), .resolveMispredict(resolveMispredict));

  // XOR-mode instance
  logic [PC_W-1:0]   xLookupPc = '0;
  logic              xPredTaken;
  logic [HIST_W-1:0] xPredHist;
  logic              xResolveValid = 1'b0;
  logic [PC_W-1:0]   xResolvePc = '0;
  logic [HIST_W-1:0] xResolveHist = '0;
  logic              xResolveTaken = 1'b0;
  logic              xResolveMispredict = 1'b0;

  bp2l_predictor #(.PC_W(PC_W), .PC_IDX_W(4), .HIST_W(HIST_W), .INDEX_MODE(IDX_XOR)) u_bp2l_predictorXor (
    .clk(clk), .rstN(rstN), .lookupPc(xLookupPc), .predTaken(xPredTaken), .predHist(xPredHist),
    .resolveValid(xResolveValid), .resolvePc(xResolvePc), .resolveHist(xResolveHist),
    .resolveTaken(xResolveTaken), .resolveMispredict(xResolveMispredict));

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic doResolve(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] hist,
                           input logic taken, input logic mis);
    @(negedge clk);
    resolveValid = 1'b1; resolvePc = pc; resolveHist = hist;
    resolveTaken = taken; resolveMispredict = mis;
    @(negedge clk);
    resolveValid = 1'b0;
  endtask

  // force history to h through a mispredicted resolve of branch B
  task automatic setHist(input logic [HIST_W-1:0] h);
    doResolve(PC_B, {1'b0, h[HIST_W-1:1]}, h[0], 1'b1);
  endtask

  task automatic lookupCheck(input string req, input logic [PC_W-1:0] pc, input logic expTaken);
    @(negedge clk);
    lookupPc = pc;
    #1;
    check(req, int'(predTaken), int'(expTaken));
  endtask

  task automatic testReset();
    @(negedge clk); lookupPc = PC_A; #1;
    check("R1 pred A", int'(predTaken), 0);
    check("R1 hist", int'(predHist), 0);
    lookupCheck("R1 pred B", PC_B, 1'b0);
    @(negedge clk); xLookupPc = 32'h4; #1;
    check("R1 xor pred", int'(xPredTaken), 0);
  endtask

  task automatic testSaturation();
    // entry (A,000) starts at 01
    logic outc [9] = '{1, 1, 1, 0, 0, 0, 0, 1, 1};
    logic expd [9] = '{1, 1, 1, 1, 0, 0, 0, 0, 1};
    for (int k = 0; k < 9; k++) begin
      doResolve(PC_A, 3'b000, outc[k], 1'b1);
      setHist(3'b000);
      lookupCheck($sformatf("R3 R2 step %0d", k), PC_A, expd[k]);
    end
  endtask

  task automatic testIndexBits();
    // (A,000) now at 10; PC differs only outside bits 5:2
    lookupCheck("R7 upper bits ignored", 32'h0000_0110, 1'b1);
    lookupCheck("R7 low bits ignored", 32'h0000_0013, 1'b1);
    lookupCheck("R7 other pc bits", 32'h0000_0014, 1'b0);
  endtask

  task automatic testSnapshot();
    setHist(3'b101);
    doResolve(PC_A, 3'b010, 1'b1, 1'b0);
    doResolve(PC_A, 3'b010, 1'b1, 1'b0);
    #1;
    check("R4 shift from 101", int'(predHist), 3'b111);
    setHist(3'b010);
    lookupCheck("R6 snapshot entry trained", PC_A, 1'b1);
    setHist(3'b101);
    lookupCheck("R6 live-history entry untouched", PC_A, 1'b0);
  endtask

  task automatic testRestore();
    // history is 101
    doResolve(PC_B, 3'b010, 1'b0, 1'b1);
    #1;
    check("R5 restore", int'(predHist), 3'b100);
    doResolve(PC_B, 3'b110, 1'b1, 1'b0);
    #1;
    check("R4 shift ignores snapshot", int'(predHist), 3'b001);
  endtask

  task automatic testIdle();
    logic p0;
    @(negedge clk); lookupPc = PC_A; #1;
    p0 = predTaken;
    repeat (3) @(negedge clk);
    #1;
    check("R10 hist held", int'(predHist), 3'b001);
    check("R10 pred held", int'(predTaken), int'(p0));
  endtask

  task automatic testLoopPattern();
    int missEarly = 0;
    int missLate = 0;
    for (int rep = 0; rep < 12; rep++) begin
      for (int pos = 0; pos < 4; pos++) begin
        logic o;
        logic p;
        logic [HIST_W-1:0] snap;
        o = (pos != 3);
        @(negedge clk);
        lookupPc = PC_A;
        #1;
        p = predTaken;
        snap = predHist;
        if (p != o && rep < 3) missEarly++;
        if (p != o && rep >= 8) missLate++;
        resolveValid = 1'b1; resolvePc = PC_A; resolveHist = snap;
        resolveTaken = o; resolveMispredict = (p != o);
        @(negedge clk);
        resolveValid = 1'b0;
      end
    end
    check("R9 learning misses", int'(missEarly > 0), 1);
    check("R9 trained misses", missLate, 0);
  endtask

  task automatic testXor();
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      xResolveValid = 1'b1; xResolvePc = 32'h10; xResolveHist = 3'b100;
      xResolveTaken = 1'b1; xResolveMispredict = 1'b1;
      @(negedge clk);
      xResolveValid = 1'b0;
    end
    #1;
    check("R8 xor hist", int'(xPredHist), 3'b001);
    @(negedge clk); xLookupPc = 32'h04; #1;
    check("R8 xor alias shares counter", int'(xPredTaken), 1);
    @(negedge clk); xLookupPc = 32'h0C; #1;
    check("R8 xor other index", int'(xPredTaken), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSaturation();
    testIndexBits();
    testSnapshot();
    testRestore();
    testIdle();
    testLoopPattern();
    testXor();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule